// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block groups two or three independent down-counting timer channels behind one byte-addressed register bus. A shared run register starts and stops the channels, one bit per channel. Each channel has its own window of 32-bit registers: a reload value, a live count and a control word. The third channel also has a plain storage register for a captured value. A single-bit output-control register sits at the bottom of the map when a parameter includes it.

Each running channel divides the clock by a programmable power of four and decrements its count once per divided tick. A tick that finds the count at zero reloads it and sets an underflow flag. The channel's interrupt line is the flag gated by an enable bit. An access to an address that is not mapped, to a misaligned address, or with a forbidden value is ignored. Such a read returns zero, and the access raises a one-cycle error pulse.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset the run register and the output-control register read 0, so every channel is stopped. Each channel's reload and count registers read 0xFFFFFFFF, its control word reads 0, and every interrupt output is low.
- R2: Byte map: 0x00 output control, 0x04 run register. Channel windows start at 0x08, 0x14 and 0x20. Inside a window, +0 is reload, +4 is count and +8 is control. A read presents its data on busRdata on the cycle after busRd is sampled. busRdata is 0 in cycles that follow no read.
- R3: Run register bit n runs channel n. A read returns the written channel bits, and bits above the channel count read 0.
- R4: Control bits [2:0] pick the divider. Code c (0..4) gives one tick every 4^(c+1) clocks. Codes 5..7 make the whole control write illegal.
- R5: A running channel decrements once per tick. A tick that finds the count at 0 loads the reload value and sets the underflow flag (control bit 8).
- R6: A channel's interrupt output equals its underflow flag AND its enable bit (control bit 5). A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it unchanged.
- R7: The output-control register stores only bit 0 and exists only when HAS_OUT_CTL is 1. Otherwise 0x00 is illegal.
- R8: With NUM_CH = 2, every address from 0x20 up is illegal, and a run-register write with bit 2 set is illegal.
- R9: A misaligned or unmapped access, or a forbidden value as in R4 and R8, is ignored. If it is a read it returns 0. busErr is high for exactly the cycle after the access.
- R10: Only the third channel has a capture storage register, at 0x2C. It resets to 0 and reads back the last value written.
- R11: A stopped channel holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe (takes priority over busRd) |
| busRd | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after busRd |
| busErr | output | 1 | One-cycle pulse after an illegal access |
| chIrq | output | NUM_CH | Per-channel interrupt |
| outCtl | output | 1 | Stored output-control bit |

## Verification
The bench aims at the exact tick count of a run and stop window at two divider settings. A prescaler that did not restart, or that compared against the wrong limit, would leave a different count behind. It drives a channel through underflow and checks that the count reloads and that the flag, the enable bit and the clear-on-zero write behave independently. A design that merged the enable with the flag, or that cleared the flag on every write, would show the wrong interrupt level. A two-channel copy with no output-control register receives writes to the third window, to bit 2 of the run register and to 0x00. A decoder that let any of these through would store data or miss the error pulse.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int MAX_CH = 3;
  localparam int PRE_W  = 10;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_CAPT   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrOut;
    logic              wrStart;
    logic [MAX_CH-1:0] wrCh;
    logic              rdOut;
    logic              rdStart;
    logic [MAX_CH-1:0] rdCh;
    regSel_e           sel;
    logic              err;
  } strobe_t;
endpackage

// File: rtl/tmu_chan.sv
module tmu_chan
  import tmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_CAPT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        wrEn,
  input  regSel_e     sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdVal,
  output logic        irq
);
  logic [CNT_W-1:0] reloadQ, cntQ;
  logic [2:0]       divQ;
  logic             ieQ, flagQ;
  logic [PRE_W-1:0] preQ, preLast;
  logic [31:0]      captVal;
  logic             tick, ctrlWr;

  assign ctrlWr = wrEn && (sel == SEL_CTRL);

  always_comb begin
    case (divQ)
      3'd0:    preLast = PRE_W'(3);
      3'd1:    preLast = PRE_W'(15);
      3'd2:    preLast = PRE_W'(63);
      3'd3:    preLast = PRE_W'(255);
      default: preLast = PRE_W'(1023);
    endcase
  end

  assign tick = run && (preQ == preLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (!run || ctrlWr || tick) begin
      preQ <= '0;
    end else begin
      preQ <= preQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '1;
      cntQ    <= '1;
      divQ    <= '0;
      ieQ     <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (wrEn && sel == SEL_RELOAD) reloadQ <= wdata[CNT_W-1:0];
      if (wrEn && sel == SEL_COUNT) begin
        cntQ <= wdata[CNT_W-1:0];
      end else if (tick) begin
        cntQ <= (cntQ == '0) ? reloadQ : cntQ - 1'b1;
      end
      if (ctrlWr) begin
        divQ <= wdata[2:0];
        ieQ  <= wdata[5];
      end
      if (tick && cntQ == '0) begin
        flagQ <= 1'b1;
      end else if (ctrlWr && !wdata[8]) begin
        flagQ <= 1'b0;
      end
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      logic [31:0] captQ;
      always_ff @(posedge clk) begin
        if (!rstN)                      captQ <= '0;
        else if (wrEn && sel == SEL_CAPT) captQ <= wdata;
      end
      assign captVal = captQ;
    end else begin : g_nocapt
      assign captVal = '0;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_RELOAD: rdVal = 32'(reloadQ);
      SEL_COUNT:  rdVal = 32'(cntQ);
      SEL_CTRL:   rdVal = {23'd0, flagQ, 2'd0, ieQ, 2'd0, divQ};
      default:    rdVal = captVal;
    endcase
  end

  assign irq = flagQ && ieQ;
endmodule

// File: rtl/tmu_ctrl.sv
module tmu_ctrl
  import tmu_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter bit HAS_OUT_CTL = 1'b1
) (
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busAddr,
  input  logic [2:0] wLow,
  output strobe_t    stb
);
  logic [5:0]        word;
  logic              legal, isOut, isStart, access, doRd;
  logic [MAX_CH-1:0] chHit;
  regSel_e           sel;

  assign word   = busAddr[7:2];
  assign access = busWr || busRd;
  assign doRd   = busRd && !busWr;

  always_comb begin
    legal   = 1'b0;
    isOut   = 1'b0;
    isStart = 1'b0;
    chHit   = '0;
    sel     = SEL_RELOAD;
    case (word)
      6'd0: begin legal = HAS_OUT_CTL; isOut = 1'b1; end
      6'd1: begin
        isStart = 1'b1;
        legal   = !(busWr && NUM_CH == 2 && wLow[2]);
      end
      6'd2, 6'd3, 6'd4: begin
        legal = 1'b1; chHit[0] = 1'b1; sel = regSel_e'(word - 6'd2);
      end
      6'd5, 6'd6, 6'd7: begin
        legal = 1'b1; chHit[1] = 1'b1; sel = regSel_e'(word - 6'd5);
      end
      6'd8, 6'd9, 6'd10, 6'd11: begin
        legal = (NUM_CH == 3); chHit[2] = 1'b1; sel = regSel_e'(word - 6'd8);
      end
      default: legal = 1'b0;
    endcase
    if (busWr && (chHit != '0) && sel == SEL_CTRL && wLow > 3'd4) legal = 1'b0;
    if (busAddr[1:0] != 2'b00) legal = 1'b0;
  end

  always_comb begin
    stb         = '0;
    stb.sel     = sel;
    stb.err     = access && !legal;
    stb.wrOut   = busWr && legal && isOut;
    stb.wrStart = busWr && legal && isStart;
    stb.wrCh    = (busWr && legal) ? chHit : '0;
    stb.rdOut   = doRd && legal && isOut;
    stb.rdStart = doRd && legal && isStart;
    stb.rdCh    = (doRd && legal) ? chHit : '0;
  end
endmodule

// File: rtl/tmu_dp.sv
module tmu_dp
  import tmu_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic [NUM_CH-1:0] chIrq,
  output logic              outCtl
);
  logic [NUM_CH-1:0] startQ;
  logic              outQ;
  logic [31:0]       chRd [MAX_CH];
  logic [31:0]       rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      outQ   <= 1'b0;
    end else begin
      if (stb.wrStart) startQ <= busWdata[NUM_CH-1:0];
      if (stb.wrOut)   outQ   <= busWdata[0];
    end
  end

  generate
    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
      if (g < NUM_CH) begin : g_on
        tmu_chan #(.CNT_W(CNT_W), .HAS_CAPT(g == 2)) u_chan (
          .clk   (clk),
          .rstN  (rstN),
          .run   (startQ[g]),
          .wrEn  (stb.wrCh[g]),
          .sel   (stb.sel),
          .wdata (busWdata),
          .rdVal (chRd[g]),
          .irq   (chIrq[g])
        );
      end else begin : g_off
        assign chRd[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    if (stb.rdOut)   rdNext = {31'd0, outQ};
    if (stb.rdStart) rdNext = 32'(startQ);
    for (int i = 0; i < MAX_CH; i++) begin
      if (stb.rdCh[i]) rdNext = chRd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busRdata <= rdNext;
      busErr   <= stb.err;
    end
  end

  assign outCtl = outQ;
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
  import tmu_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter bit HAS_OUT_CTL = 1'b1,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic [NUM_CH-1:0] chIrq,
  output logic              outCtl
);
  strobe_t stb;

  tmu_ctrl #(.NUM_CH(NUM_CH), .HAS_OUT_CTL(HAS_OUT_CTL)) u_ctrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .wLow    (busWdata[2:0]),
    .stb     (stb)
  );

  tmu_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busErr   (busErr),
    .chIrq    (chIrq),
    .outCtl   (outCtl)
  );
endmodule

// File: rtl/multi_timer_unit_chk.sv
module multi_timer_unit_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busErr,
  input logic [NUM_CH-1:0] chIrq
);
  // R9: error pulse only follows an access
  a_r9_err_after_access: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWr || busRd));

  // R9: a refused read returns zero
  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && $past(busRd && !busWr)) |-> (busRdata == 32'd0));

  // R9: misaligned access is refused
  a_r9_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    ((busWr || busRd) && busAddr[1:0] != 2'b00) |=> busErr);

  // R8: third window absent in the two-channel build
  a_r8_no_third_window: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_CH == 2 && (busWr || busRd) && busAddr >= 8'h20) |=> busErr);

  // R8: run bit 2 forbidden in the two-channel build
  a_r8_start_bit2: assert property (@(posedge clk) disable iff (!rstN)
    (NUM_CH == 2 && busWr && busAddr == 8'h04 && busWdata[2]) |=> busErr);

  // R4: reserved divider codes are refused
  a_r4_bad_div: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h10 && busWdata[2:0] > 3'd4) |=> busErr);

  // R6: clearing the enable drops channel 0's interrupt
  a_r6_ie_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h10 && !busWdata[5] && busWdata[2:0] <= 3'd4) |=> !chIrq[0]);
endmodule

bind multi_timer_unit multi_timer_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busRd    (busRd),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .busErr   (busErr),
  .chIrq    (chIrq)
);

// File: tb/multi_timer_unit_tb.sv
module multi_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrA = 0, rdA = 0, wrB = 0, rdB = 0;
  logic [7:0]  addrA = 0, addrB = 0;
  logic [31:0] wdA = 0, wdB = 0;
  logic [31:0] rdataA, rdataB;
  logic        errA, errB, outA, outB;
  logic [2:0]  irqA;
  logic [1:0]  irqB;
  int          nChk = 0, nFail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  multi_timer_unit #(.NUM_CH(3), .HAS_OUT_CTL(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(wrA), .busRd(rdA), .busAddr(addrA),
    .busWdata(wdA), .busRdata(rdataA), .busErr(errA), .chIrq(irqA), .outCtl(outA));

  multi_timer_unit #(.NUM_CH(2), .HAS_OUT_CTL(1'b0)) u_dut2 (
    .clk(clk), .rstN(rstN), .busWr(wrB), .busRd(rdB), .busAddr(addrB),
    .busWdata(wdB), .busRdata(rdataB), .busErr(errB), .chIrq(irqB), .outCtl(outB));

  // {wr, addr, wdata, expected read data, expected error}
  localparam int NV = 24;
  localparam logic [73:0] VECS [NV] = '{
    {1'b0, 8'h04, 32'h0,        32'h0,        1'b0}, // R1
    {1'b0, 8'h08, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1
    {1'b0, 8'h0C, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1
    {1'b0, 8'h00, 32'h0,        32'h0,        1'b0}, // R1
    {1'b1, 8'h00, 32'hFF,       32'h0,        1'b0}, // R7
    {1'b0, 8'h00, 32'h0,        32'h1,        1'b0}, // R7
    {1'b1, 8'h14, 32'h1234,     32'h0,        1'b0}, // R2
    {1'b0, 8'h14, 32'h0,        32'h1234,     1'b0}, // R2
    {1'b1, 8'h2C, 32'hCAFE,     32'h0,        1'b0}, // R10
    {1'b0, 8'h2C, 32'h0,        32'hCAFE,     1'b0}, // R10
    {1'b1, 8'h18, 32'h55,       32'h0,        1'b0}, // R11
    {1'b0, 8'h18, 32'h0,        32'h55,       1'b0}, // R11
    {1'b1, 8'h01, 32'h9,        32'h0,        1'b1}, // R9
    {1'b0, 8'h01, 32'h0,        32'h0,        1'b1}, // R9
    {1'b1, 8'h30, 32'h9,        32'h0,        1'b1}, // R9
    {1'b0, 8'h30, 32'h0,        32'h0,        1'b1}, // R9
    {1'b1, 8'h1C, 32'h5,        32'h0,        1'b1}, // R4
    {1'b0, 8'h1C, 32'h0,        32'h0,        1'b0}, // R4
    {1'b1, 8'h20, 32'h77,       32'h0,        1'b0}, // R2
    {1'b0, 8'h20, 32'h0,        32'h77,       1'b0}, // R2
    {1'b1, 8'h04, 32'hFD,       32'h0,        1'b0}, // R3
    {1'b0, 8'h04, 32'h0,        32'h5,        1'b0}, // R3
    {1'b1, 8'h04, 32'h0,        32'h0,        1'b0}, // R3
    {1'b0, 8'h04, 32'h0,        32'h0,        1'b0}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit second, input bit wr, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    if (second) begin wrB = wr; rdB = !wr; addrB = a; wdB = d; end
    else        begin wrA = wr; rdA = !wr; addrA = a; wdA = d; end
    @(negedge clk);
    rd = second ? rdataB : rdataA;
    er = second ? errB : errA;
    wrA = 0; rdA = 0; wrB = 0; rdB = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          waitN;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", 32'(irqA), 32'h0);
    check("R1 outCtl after reset", 32'(outA), 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(1'b0, VECS[i][73], VECS[i][72:65], VECS[i][64:33], rd, er);
      check($sformatf("R2/R9 vector %0d err", i), 32'(er), 32'(VECS[i][0]));
      if (!VECS[i][73]) check($sformatf("R2 vector %0d data", i), rd, VECS[i][32:1]);
    end
    check("R7 outCtl bit", 32'(outA), 32'h1);

    // R4 R5 R11: divide-by-4 run window on channel 0
    acc(0, 1, 8'h08, 32'd3, rd, er);
    acc(0, 1, 8'h0C, 32'd10, rd, er);
    acc(0, 1, 8'h10, 32'h20, rd, er);
    acc(0, 1, 8'h04, 32'h1, rd, er);
    repeat (20) @(negedge clk);
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    check("R4 count after 21 clocks at div4", rd, 32'd5);
    repeat (10) @(negedge clk);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    check("R11 stopped count holds", rd, 32'd5);

    // R5 R6: underflow and reload
    acc(0, 1, 8'h04, 32'h1, rd, er);
    waitN = 0;
    while (!irqA[0] && waitN < 200) begin @(negedge clk); waitN++; end
    acc(0, 1, 8'h04, 32'h0, rd, er);
    check("R6 irq on underflow", 32'(irqA[0]), 32'h1);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    check("R5 count reloaded", rd, 32'd3);
    acc(0, 0, 8'h10, 32'h0, rd, er);
    check("R5 flag in control", rd, 32'h120);
    acc(0, 1, 8'h10, 32'h120, rd, er);
    check("R6 flag kept on bit8=1", 32'(irqA[0]), 32'h1);
    acc(0, 1, 8'h10, 32'h100, rd, er);
    check("R6 irq off with enable low", 32'(irqA[0]), 32'h0);
    acc(0, 0, 8'h10, 32'h0, rd, er);
    check("R6 flag survives enable low", rd, 32'h100);
    acc(0, 1, 8'h10, 32'h20, rd, er);
    acc(0, 0, 8'h10, 32'h0, rd, er);
    check("R6 flag cleared by bit8=0", rd, 32'h20);
    check("R6 irq stays low", 32'(irqA[0]), 32'h0);

    // R4 R3: divide-by-16 on channel 1 only
    acc(0, 1, 8'h1C, 32'h1, rd, er);
    acc(0, 1, 8'h18, 32'd100, rd, er);
    acc(0, 1, 8'h04, 32'h2, rd, er);
    repeat (40) @(negedge clk);
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 0, 8'h18, 32'h0, rd, er);
    check("R4 count after 41 clocks at div16", rd, 32'd98);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    check("R3 channel 0 unaffected by bit1", rd, 32'd3);

    // R8 R7: two-channel build without output control
    acc(1, 1, 8'h20, 32'h11, rd, er);
    check("R8 third window write refused", 32'(er), 32'h1);
    acc(1, 0, 8'h20, 32'h0, rd, er);
    check("R8 third window read err", 32'(er), 32'h1);
    check("R8 third window read zero", rd, 32'h0);
    acc(1, 1, 8'h04, 32'h4, rd, er);
    check("R8 run bit2 refused", 32'(er), 32'h1);
    acc(1, 0, 8'h04, 32'h0, rd, er);
    check("R8 run register unchanged", rd, 32'h0);
    acc(1, 1, 8'h00, 32'h1, rd, er);
    check("R7 absent out-control write err", 32'(er), 32'h1);
    check("R7 absent out-control not stored", 32'(outB), 32'h0);
    acc(1, 1, 8'h04, 32'h3, rd, er);
    check("R3 two-channel run write ok", 32'(er), 32'h0);
    acc(1, 0, 8'h04, 32'h0, rd, er);
    check("R3 two-channel run readback", rd, 32'h3);
    acc(1, 1, 8'h04, 32'h0, rd, er);
    @(negedge clk);
    check("R9 err is one cycle", 32'(errB), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule